// File: doc/BRIEF.md
# Board User-I/O Controller

This block connects a board's user-facing indicators and controls to a 32-bit AXI4-Lite register slave. It drives two seven-segment digits with their decimal points, four red and four green status LEDs, and two red/green indicator pairs. Each output bit, or each hex segment group, is driven either from a register that software writes or from a matching hardware user-port input. A control register picks the source for each one separately.

Four DIP switches and three push buttons (up, middle, down) enter through two-flop synchronizers and then debouncers. The debounced levels appear in a read-only status register. The same levels are also driven out on user-side ports, so other fabric logic can use them without going through the bus. A parameter sets the polarity of the hex display pins. With the default active-low setting, every segment and decimal-point pin is inverted.

Top module: `userio_ctrl`

## Requirements
- R1: After rst_ni is asserted low, all source-select bits and data registers read as 0 and all debounced values are 0. Every LED output is then 0, and with the active-low hex option every hex segment and decimal-point output is 1.
- R2: A write completes when the write address and the write data are presented together, address first, or data first. The write response (bvalid with bresp 00) is raised only after both have been accepted, and it stays high until bready is seen.
- R3: A read returns its data with rresp 00. rvalid and rdata stay steady until rready is seen.
- R4: Control bits 11:0 select the source of each LED output bit, where 0 means the software data register and 1 means the user-port input. The LED data register at offset 0x04 maps bits 3:0 to red LEDs 0..3, bits 7:4 to green LEDs 0..3, bit 8 to channel A red, bit 9 to channel A green, bit 10 to channel B red and bit 11 to channel B green. Control bit n uses the same bit numbering.
- R5: Control bits 12 (left segments), 13 (left point), 14 (right segments) and 15 (right point) select the source of each hex group. The hex data register at offset 0x08 holds the left segments in bits 6:0, the left point in bit 7, the right segments in bits 14:8 and the right point in bit 15.
- R6: With the active-low hex option (the default), each hex segment and decimal-point output is the inverse of the selected source bit.
- R7: A debounced value changes only after its synchronized raw input has differed from it for DEB_CYCLES consecutive clocks. A raw change at a falling edge appears at the output after DEB_CYCLES+2 rising edges. A pulse shorter than DEB_CYCLES clocks has no effect.
- R8: The status register at offset 0x0C holds the debounced DIP switches in bits 3:0, up in bit 4, middle in bit 5 and down in bit 6. All other bits read 0.
- R9: The user-side outputs usr_dip_o, usr_btn_up_o, usr_btn_mid_o and usr_btn_dn_o always equal the debounced values.
- R10: A write to the status register or to an unmapped offset changes no register but still gets an OKAY response. A read of an unmapped offset returns 0 with OKAY.
- R11: Write byte strobes are honoured. Only the bytes whose wstrb bit is 1 are updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_awaddr_i | input | AW | Write address |
| s_awvalid_i | input | 1 | Write address valid |
| s_awready_o | output | 1 | Write address ready |
| s_wdata_i | input | 32 | Write data |
| s_wstrb_i | input | 4 | Write byte strobes |
| s_wvalid_i | input | 1 | Write data valid |
| s_wready_o | output | 1 | Write data ready |
| s_bresp_o | output | 2 | Write response |
| s_bvalid_o | output | 1 | Write response valid |
| s_bready_i | input | 1 | Write response ready |
| s_araddr_i | input | AW | Read address |
| s_arvalid_i | input | 1 | Read address valid |
| s_arready_o | output | 1 | Read address ready |
| s_rdata_o | output | 32 | Read data |
| s_rresp_o | output | 2 | Read response |
| s_rvalid_o | output | 1 | Read data valid |
| s_rready_i | input | 1 | Read data ready |
| hex_l_seg_o | output | 7 | Left digit segments |
| hex_l_dp_o | output | 1 | Left decimal point |
| hex_r_seg_o | output | 7 | Right digit segments |
| hex_r_dp_o | output | 1 | Right decimal point |
| led_red_o | output | 4 | Red status LEDs |
| led_grn_o | output | 4 | Green status LEDs |
| rf_a_red_o | output | 1 | Channel A red indicator |
| rf_a_grn_o | output | 1 | Channel A green indicator |
| rf_b_red_o | output | 1 | Channel B red indicator |
| rf_b_grn_o | output | 1 | Channel B green indicator |
| usr_hex_l_seg_i | input | 7 | Hardware source, left segments |
| usr_hex_l_dp_i | input | 1 | Hardware source, left point |
| usr_hex_r_seg_i | input | 7 | Hardware source, right segments |
| usr_hex_r_dp_i | input | 1 | Hardware source, right point |
| usr_led_red_i | input | 4 | Hardware source, red LEDs |
| usr_led_grn_i | input | 4 | Hardware source, green LEDs |
| usr_rf_a_red_i | input | 1 | Hardware source, channel A red |
| usr_rf_a_grn_i | input | 1 | Hardware source, channel A green |
| usr_rf_b_red_i | input | 1 | Hardware source, channel B red |
| usr_rf_b_grn_i | input | 1 | Hardware source, channel B green |
| dip_i | input | 4 | Raw DIP switches |
| btn_up_i | input | 1 | Raw up button |
| btn_mid_i | input | 1 | Raw middle button |
| btn_dn_i | input | 1 | Raw down button |
| usr_dip_o | output | 4 | Debounced DIP switches |
| usr_btn_up_o | output | 1 | Debounced up button |
| usr_btn_mid_o | output | 1 | Debounced middle button |
| usr_btn_dn_o | output | 1 | Debounced down button |

## Verification
The bench drives the write address and write data in all three orders while holding bready low. A design that commits on the address alone, or that drops bvalid early, either writes stale data or loses the response. It mixes the two sources bit by bit, with the user-port inputs set to the complement of the register data, so a swapped select or a mis-wired bit shows up as a flipped LED. The hex groups are tested the same way under active-low polarity, which exposes a missing or misplaced inversion. The debounce test checks one cycle before and at the exact switching edge, and also applies a pulse one clock short. An off-by-one counter or a counter that does not restart then moves the switch early, late, or on the glitch. Partial-strobe writes, writes to the status register and accesses to unmapped offsets must leave every register unchanged.

// File: rtl/userio_pkg.sv
package userio_pkg;
  localparam int DATA_W = 32;
  localparam int STRB_W = DATA_W / 8;
  localparam int LED_W  = 12;
  localparam int HEX_W  = 16;
  localparam int CTRL_W = LED_W + 4;
  localparam int IN_W   = 7;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_LED    = 2'd1,
    REG_HEX    = 2'd2,
    REG_STATUS = 2'd3
  } reg_idx_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/userio_debounce.sv
module userio_debounce #(
  parameter int DEB_CYCLES = 65536
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic deb_o
);
  localparam int CNT_W = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DEB_CYCLES - 1);

  logic [1:0]       sync_q;
  logic [CNT_W-1:0] cnt_q;
  logic             state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= '0;
      cnt_q   <= '0;
      state_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      if (sync_q[1] == state_q) begin
        cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
        state_q <= sync_q[1];
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign deb_o = state_q;

  AST_DEB_FLIP_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> ($past(cnt_q) == CNT_LAST)); // R7
  AST_DEB_FLIP_TO_SYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> (state_q == $past(sync_q[1]))); // R7
endmodule

// File: rtl/userio_outmux.sv
module userio_outmux #(
  parameter int W      = 12,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] sw_i,
  input  logic [W-1:0] hw_i,
  input  logic [W-1:0] sel_i,
  output logic [W-1:0] out_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic pick;
    assign pick = sel_i[i] ? hw_i[i] : sw_i[i];
    if (INVERT) begin : g_inv
      assign out_o[i] = ~pick;
    end else begin : g_dir
      assign out_o[i] = pick;
    end
  end
endmodule

// File: rtl/userio_axil.sv
module userio_axil
  import userio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     awaddr_i,
  input  logic              awvalid_i,
  output logic              awready_o,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [STRB_W-1:0] wstrb_i,
  input  logic              wvalid_i,
  output logic              wready_o,
  output logic [1:0]        bresp_o,
  output logic              bvalid_o,
  input  logic              bready_i,
  input  logic [AW-1:0]     araddr_i,
  input  logic              arvalid_i,
  output logic              arready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        rresp_o,
  output logic              rvalid_o,
  input  logic              rready_i,
  input  logic [IN_W-1:0]   status_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [LED_W-1:0]  led_o,
  output logic [HEX_W-1:0]  hex_o
);
  logic              aw_full_q, w_full_q, bvalid_q, rvalid_q;
  logic [AW-1:0]     aw_q;
  logic [DATA_W-1:0] wd_q, rdata_q, wmask, rd_next;
  logic [STRB_W-1:0] ws_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LED_W-1:0]  led_q;
  logic [HEX_W-1:0]  hex_q;
  logic              commit, w_hit, r_hit;
  logic [1:0]        w_idx, r_idx;

  assign awready_o = !aw_full_q;
  assign wready_o  = !w_full_q;
  assign arready_o = !rvalid_q;
  assign commit    = aw_full_q && w_full_q && !bvalid_q;
  assign w_hit     = (aw_q[AW-1:4] == '0);
  assign w_idx     = aw_q[3:2];
  assign r_hit     = (araddr_i[AW-1:4] == '0);
  assign r_idx     = araddr_i[3:2];

  always_comb begin
    for (int b = 0; b < STRB_W; b++) wmask[b*8 +: 8] = {8{ws_q[b]}};
  end

  always_comb begin
    rd_next = '0;
    if (r_hit) begin
      unique case (reg_idx_e'(r_idx))
        REG_CTRL:   rd_next = DATA_W'(ctrl_q);
        REG_LED:    rd_next = DATA_W'(led_q);
        REG_HEX:    rd_next = DATA_W'(hex_q);
        REG_STATUS: rd_next = DATA_W'(status_i);
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aw_full_q <= 1'b0;
      w_full_q  <= 1'b0;
      bvalid_q  <= 1'b0;
      aw_q      <= '0;
      wd_q      <= '0;
      ws_q      <= '0;
      ctrl_q    <= '0;
      led_q     <= '0;
      hex_q     <= '0;
    end else begin
      if (awvalid_i && !aw_full_q) begin
        aw_full_q <= 1'b1;
        aw_q      <= awaddr_i;
      end
      if (wvalid_i && !w_full_q) begin
        w_full_q <= 1'b1;
        wd_q     <= wdata_i;
        ws_q     <= wstrb_i;
      end
      if (commit) begin
        aw_full_q <= 1'b0;
        w_full_q  <= 1'b0;
        bvalid_q  <= 1'b1;
        if (w_hit) begin
          case (reg_idx_e'(w_idx))
            REG_CTRL: ctrl_q <= (ctrl_q & ~wmask[CTRL_W-1:0]) | (wd_q[CTRL_W-1:0] & wmask[CTRL_W-1:0]);
            REG_LED:  led_q  <= (led_q & ~wmask[LED_W-1:0]) | (wd_q[LED_W-1:0] & wmask[LED_W-1:0]);
            REG_HEX:  hex_q  <= (hex_q & ~wmask[HEX_W-1:0]) | (wd_q[HEX_W-1:0] & wmask[HEX_W-1:0]);
            default: ;
          endcase
        end
      end else if (bvalid_q && bready_i) begin
        bvalid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else if (arvalid_i && !rvalid_q) begin
      rvalid_q <= 1'b1;
      rdata_q  <= rd_next;
    end else if (rvalid_q && rready_i) begin
      rvalid_q <= 1'b0;
    end
  end

  assign bvalid_o = bvalid_q;
  assign bresp_o  = RESP_OKAY;
  assign rvalid_o = rvalid_q;
  assign rdata_o  = rdata_q;
  assign rresp_o  = RESP_OKAY;
  assign ctrl_o   = ctrl_q;
  assign led_o    = led_q;
  assign hex_o    = hex_q;

  AST_B_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bvalid_o && !bready_i) |=> bvalid_o); // R2
  AST_B_AFTER_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bvalid_o) |-> ($past(aw_full_q) && $past(w_full_q))); // R2
  AST_R_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rvalid_o && !rready_i) |=> (rvalid_o && $stable(rdata_o))); // R3
  AST_REGS_ONLY_ON_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(commit) |-> ($stable(ctrl_q) && $stable(led_q) && $stable(hex_q))); // R10
endmodule

// File: rtl/userio_ctrl.sv
module userio_ctrl
  import userio_pkg::*;
#(
  parameter int AW              = 8,
  parameter int DEB_CYCLES      = 65536,
  parameter bit HEX_ACTIVE_HIGH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     s_awaddr_i,
  input  logic              s_awvalid_i,
  output logic              s_awready_o,
  input  logic [31:0]       s_wdata_i,
  input  logic [3:0]        s_wstrb_i,
  input  logic              s_wvalid_i,
  output logic              s_wready_o,
  output logic [1:0]        s_bresp_o,
  output logic              s_bvalid_o,
  input  logic              s_bready_i,
  input  logic [AW-1:0]     s_araddr_i,
  input  logic              s_arvalid_i,
  output logic              s_arready_o,
  output logic [31:0]       s_rdata_o,
  output logic [1:0]        s_rresp_o,
  output logic              s_rvalid_o,
  input  logic              s_rready_i,
  output logic [6:0]        hex_l_seg_o,
  output logic              hex_l_dp_o,
  output logic [6:0]        hex_r_seg_o,
  output logic              hex_r_dp_o,
  output logic [3:0]        led_red_o,
  output logic [3:0]        led_grn_o,
  output logic              rf_a_red_o,
  output logic              rf_a_grn_o,
  output logic              rf_b_red_o,
  output logic              rf_b_grn_o,
  input  logic [6:0]        usr_hex_l_seg_i,
  input  logic              usr_hex_l_dp_i,
  input  logic [6:0]        usr_hex_r_seg_i,
  input  logic              usr_hex_r_dp_i,
  input  logic [3:0]        usr_led_red_i,
  input  logic [3:0]        usr_led_grn_i,
  input  logic              usr_rf_a_red_i,
  input  logic              usr_rf_a_grn_i,
  input  logic              usr_rf_b_red_i,
  input  logic              usr_rf_b_grn_i,
  input  logic [3:0]        dip_i,
  input  logic              btn_up_i,
  input  logic              btn_mid_i,
  input  logic              btn_dn_i,
  output logic [3:0]        usr_dip_o,
  output logic              usr_btn_up_o,
  output logic              usr_btn_mid_o,
  output logic              usr_btn_dn_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [LED_W-1:0]  led_sw, led_hw, led_out;
  logic [HEX_W-1:0]  hex_sw, hex_hw, hex_sel, hex_out;
  logic [IN_W-1:0]   raw_in, deb_in;

  userio_axil #(.AW(AW)) u_regs (
    .clk_i, .rst_ni,
    .awaddr_i(s_awaddr_i), .awvalid_i(s_awvalid_i), .awready_o(s_awready_o),
    .wdata_i(s_wdata_i), .wstrb_i(s_wstrb_i), .wvalid_i(s_wvalid_i), .wready_o(s_wready_o),
    .bresp_o(s_bresp_o), .bvalid_o(s_bvalid_o), .bready_i(s_bready_i),
    .araddr_i(s_araddr_i), .arvalid_i(s_arvalid_i), .arready_o(s_arready_o),
    .rdata_o(s_rdata_o), .rresp_o(s_rresp_o), .rvalid_o(s_rvalid_o), .rready_i(s_rready_i),
    .status_i(deb_in), .ctrl_o(ctrl), .led_o(led_sw), .hex_o(hex_sw)
  );

  assign led_hw = {usr_rf_b_grn_i, usr_rf_b_red_i, usr_rf_a_grn_i, usr_rf_a_red_i,
                   usr_led_grn_i, usr_led_red_i};
  assign hex_hw = {usr_hex_r_dp_i, usr_hex_r_seg_i, usr_hex_l_dp_i, usr_hex_l_seg_i};
  // one select bit per hex group, fanned out to its segments
  assign hex_sel = {ctrl[LED_W+3], {7{ctrl[LED_W+2]}}, ctrl[LED_W+1], {7{ctrl[LED_W]}}};

  userio_outmux #(.W(LED_W), .INVERT(1'b0)) u_led_mux (
    .sw_i(led_sw), .hw_i(led_hw), .sel_i(ctrl[LED_W-1:0]), .out_o(led_out)
  );
  userio_outmux #(.W(HEX_W), .INVERT(!HEX_ACTIVE_HIGH)) u_hex_mux (
    .sw_i(hex_sw), .hw_i(hex_hw), .sel_i(hex_sel), .out_o(hex_out)
  );

  assign {rf_b_grn_o, rf_b_red_o, rf_a_grn_o, rf_a_red_o, led_grn_o, led_red_o} = led_out;
  assign {hex_r_dp_o, hex_r_seg_o, hex_l_dp_o, hex_l_seg_o} = hex_out;

  assign raw_in = {btn_dn_i, btn_mid_i, btn_up_i, dip_i};
  for (genvar i = 0; i < IN_W; i++) begin : g_deb
    userio_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
      .clk_i, .rst_ni, .raw_i(raw_in[i]), .deb_o(deb_in[i])
    );
  end

  assign {usr_btn_dn_o, usr_btn_mid_o, usr_btn_up_o, usr_dip_o} = deb_in;

  AST_LED_SW_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[LED_W-1:0] == '0) |-> (led_out == led_sw)); // R4
  AST_HEX_HW_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hex_sel == '1) |-> ((hex_out ^ {HEX_W{!HEX_ACTIVE_HIGH}}) == hex_hw)); // R5
endmodule

// File: tb/tb_userio_ctrl.sv
module tb_userio_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 8;
  localparam int DEB = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [6:0] hl_seg, hr_seg, u_hl_seg = '0, u_hr_seg = '0;
  logic hl_dp, hr_dp, u_hl_dp = 0, u_hr_dp = 0;
  logic [3:0] led_r, led_g, u_led_r = '0, u_led_g = '0;
  logic ra_r, ra_g, rb_r, rb_g, u_ra_r = 0, u_ra_g = 0, u_rb_r = 0, u_rb_g = 0;
  logic [3:0] dip = '0, u_dip;
  logic b_up = 0, b_mid = 0, b_dn = 0, u_up, u_mid, u_dn;

  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  userio_ctrl #(.AW(AW), .DEB_CYCLES(DEB)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .s_awaddr_i(awaddr), .s_awvalid_i(awvalid), .s_awready_o(awready),
    .s_wdata_i(wdata), .s_wstrb_i(wstrb), .s_wvalid_i(wvalid), .s_wready_o(wready),
    .s_bresp_o(bresp), .s_bvalid_o(bvalid), .s_bready_i(bready),
    .s_araddr_i(araddr), .s_arvalid_i(arvalid), .s_arready_o(arready),
    .s_rdata_o(rdata), .s_rresp_o(rresp), .s_rvalid_o(rvalid), .s_rready_i(rready),
    .hex_l_seg_o(hl_seg), .hex_l_dp_o(hl_dp), .hex_r_seg_o(hr_seg), .hex_r_dp_o(hr_dp),
    .led_red_o(led_r), .led_grn_o(led_g),
    .rf_a_red_o(ra_r), .rf_a_grn_o(ra_g), .rf_b_red_o(rb_r), .rf_b_grn_o(rb_g),
    .usr_hex_l_seg_i(u_hl_seg), .usr_hex_l_dp_i(u_hl_dp),
    .usr_hex_r_seg_i(u_hr_seg), .usr_hex_r_dp_i(u_hr_dp),
    .usr_led_red_i(u_led_r), .usr_led_grn_i(u_led_g),
    .usr_rf_a_red_i(u_ra_r), .usr_rf_a_grn_i(u_ra_g),
    .usr_rf_b_red_i(u_rb_r), .usr_rf_b_grn_i(u_rb_g),
    .dip_i(dip), .btn_up_i(b_up), .btn_mid_i(b_mid), .btn_dn_i(b_dn),
    .usr_dip_o(u_dip), .usr_btn_up_o(u_up), .usr_btn_mid_o(u_mid), .usr_btn_dn_o(u_dn)
  );

  function automatic logic [11:0] led_vec();
    return {rb_g, rb_r, ra_g, ra_r, led_g, led_r};
  endfunction
  function automatic logic [15:0] hex_vec();
    return {hr_dp, hr_seg, hl_dp, hl_seg};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // mode 0: together, 1: address first, 2: data first
  task automatic axi_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int mode);
    bit aw_pend = 1, w_pend = 1, aw_fire, w_fire;
    int guard = 0;
    @(negedge clk);
    awaddr = a; wdata = d; wstrb = s; bready = 0;
    awvalid = (mode != 2); wvalid = (mode != 1);
    while ((aw_pend || w_pend) && guard < 50) begin
      aw_fire = awvalid && awready;
      w_fire  = wvalid && wready;
      @(negedge clk);
      guard++;
      if (aw_fire) begin awvalid = 0; aw_pend = 0; end
      if (w_fire)  begin wvalid = 0;  w_pend = 0;  end
      if (aw_fire && w_pend && !wvalid) wvalid = 1;
      if (w_fire && aw_pend && !awvalid) awvalid = 1;
      if (aw_pend != w_pend) chk("R2 no early response", {31'b0, bvalid}, 0);
    end
    guard = 0;
    while (!bvalid && guard < 20) begin @(negedge clk); guard++; end
    chk("R2 response raised", {31'b0, bvalid}, 1);
    chk("R2 bresp OKAY", {30'b0, bresp}, 0);
    repeat (2) @(negedge clk);
    chk("R2 response held", {31'b0, bvalid}, 1);
    bready = 1;
    @(negedge clk);
    bready = 0;
    chk("R2 response released", {31'b0, bvalid}, 0);
  endtask

  task automatic axi_read(input logic [7:0] a, output logic [31:0] d);
    int guard = 0;
    @(negedge clk);
    araddr = a; arvalid = 1; rready = 0;
    while (!arready && guard < 20) begin @(negedge clk); guard++; end
    @(negedge clk);
    arvalid = 0;
    d = rdata;
    chk("R3 rvalid", {31'b0, rvalid}, 1);
    chk("R3 rresp OKAY", {30'b0, rresp}, 0);
    @(negedge clk);
    chk("R3 rdata held", rdata, d);
    rready = 1;
    @(negedge clk);
    rready = 0;
    chk("R3 rvalid released", {31'b0, rvalid}, 0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 leds", {20'b0, led_vec()}, 0);
    chk("R1 hex active-low idle", {16'b0, hex_vec()}, 32'hFFFF);
    chk("R1 usr inputs", {25'b0, u_dn, u_mid, u_up, u_dip}, 0);
    chk("R1 bvalid/rvalid", {30'b0, bvalid, rvalid}, 0);
    axi_read(8'h00, d); chk("R1 ctrl reg", d, 0);
    axi_read(8'h04, d); chk("R1 led reg", d, 0);
    axi_read(8'h08, d); chk("R1 hex reg", d, 0);
  endtask

  task automatic t_write_orders();
    logic [31:0] d;
    axi_write(8'h04, 32'h0000_0A5C, 4'hF, 0);
    axi_read(8'h04, d); chk("R2 together", d, 32'h0A5C);
    axi_write(8'h04, 32'h0000_05A3, 4'hF, 1);
    axi_read(8'h04, d); chk("R2 addr first", d, 32'h05A3);
    axi_write(8'h04, 32'h0000_0F0F, 4'hF, 2);
    axi_read(8'h04, d); chk("R2 data first", d, 32'h0F0F);
  endtask

  task automatic t_led_mux();
    axi_write(8'h00, 32'h0, 4'hF, 0);
    axi_write(8'h04, 32'h0000_0A5C, 4'hF, 0);
    {u_rb_g, u_rb_r, u_ra_g, u_ra_r, u_led_g, u_led_r} = ~12'hA5C;
    @(negedge clk);
    chk("R4 all software", {20'b0, led_vec()}, 32'hA5C);
    axi_write(8'h00, 32'h0000_0F33, 4'hF, 0);
    chk("R4 mixed sources", {20'b0, led_vec()}, {20'b0, (12'hA5C & ~12'hF33) | (~12'hA5C & 12'hF33)});
    axi_write(8'h00, 32'h0000_0FFF, 4'hF, 0);
    chk("R4 all hardware", {20'b0, led_vec()}, {20'b0, ~12'hA5C});
  endtask

  task automatic t_hex_mux();
    axi_write(8'h00, 32'h0, 4'hF, 0);
    axi_write(8'h08, 32'h0000_B64D, 4'hF, 0);
    {u_hr_dp, u_hr_seg, u_hl_dp, u_hl_seg} = 16'h1234;
    @(negedge clk);
    chk("R6 software hex inverted", {16'b0, hex_vec()}, {16'b0, ~16'hB64D});
    axi_write(8'h00, 32'h0000_5000, 4'hF, 0); // left segs + right segs from hardware
    chk("R5 group select", {16'b0, hex_vec()},
        {16'b0, ~((16'h1234 & 16'h7F7F) | (16'hB64D & 16'h8080))});
    axi_write(8'h00, 32'h0000_A000, 4'hF, 0); // both points from hardware
    chk("R5 point select", {16'b0, hex_vec()},
        {16'b0, ~((16'h1234 & 16'h8080) | (16'hB64D & 16'h7F7F))});
  endtask

  task automatic t_strobe();
    logic [31:0] d;
    axi_write(8'h08, 32'h0000_FFFF, 4'hF, 0);
    axi_write(8'h08, 32'h0000_1234, 4'h1, 0);
    axi_read(8'h08, d); chk("R11 low byte only", d, 32'hFF34);
    axi_write(8'h08, 32'h0000_5600, 4'h2, 1);
    axi_read(8'h08, d); chk("R11 high byte only", d, 32'h5634);
  endtask

  task automatic t_debounce();
    logic [31:0] d;
    dip = 4'b1010;
    repeat (DEB + 1) @(posedge clk);
    @(negedge clk);
    chk("R7 not yet switched", {28'b0, u_dip}, 0);
    @(posedge clk); @(negedge clk);
    chk("R7 switched at limit", {28'b0, u_dip}, 32'hA);
    b_mid = 1;
    repeat (DEB - 1) @(negedge clk);
    b_mid = 0;
    repeat (3 * DEB) @(negedge clk);
    chk("R7 short pulse ignored", {31'b0, u_mid}, 0);
    b_up = 1; b_dn = 1;
    repeat (DEB + 4) @(negedge clk);
    chk("R9 usr outputs", {25'b0, u_dn, u_mid, u_up, u_dip}, {25'b0, 3'b101, 4'hA});
    axi_read(8'h0C, d); chk("R8 status layout", d, 32'h0000_005A);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    axi_write(8'h0C, 32'hFFFF_FFFF, 4'hF, 0);
    axi_read(8'h0C, d); chk("R10 status write ignored", d, 32'h0000_005A);
    axi_write(8'h10, 32'hFFFF_FFFF, 4'hF, 2);
    axi_read(8'h00, d); chk("R10 unmapped write ctrl kept", d, 32'h0000_A000);
    axi_read(8'h04, d); chk("R10 unmapped write led kept", d, 32'h0000_0A5C);
    axi_read(8'h08, d); chk("R10 unmapped write hex kept", d, 32'h0000_5634);
    axi_read(8'h10, d); chk("R10 unmapped read zero", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_write_orders();
    t_led_mux();
    t_hex_mux();
    t_strobe();
    t_debounce();
    t_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule